// File: doc/BRIEF.md
# Presence-Vector Snoop Filter

This block sits beside a coherent interconnect with a fixed set of caching nodes. It tracks which cache lines the nodes may hold, in a fully associative table. Each tracked line has one bit per node that may own it. A node's read fill sets that node's bit. A node's eviction notice clears it. A snoop to a tracked line is then forwarded only to the nodes whose bits are set, not broadcast to every node.

When a fill arrives for an untracked line and no entry is free, the block must make room. It replaces the entry that has the fewest owners, because invalidating that entry disturbs the fewest caches. Among equally shared entries it replaces the one left untouched the longest. The owners of the replaced line receive a back-invalidate that carries the line address and the owner vector.

All requests arrive on one port, at most one per cycle. Every response is registered.

Top module: `snoop_filter`

## Requirements
- R1: After reset no line is tracked. All outputs are low, and a snoop to any address returns an empty target vector.
- R2: Requests use `req_op` encoded as 0 idle, 1 fill, 2 eviction notice, 3 snoop. Bit k of every node vector stands for node k. A fill to an untracked line creates an entry that holds only the requesting node's bit. A later snoop to that line returns exactly that vector.
- R3: A fill to a tracked line adds the requesting node's bit and keeps the bits already set.
- R4: An eviction notice to a tracked line clears only the bit of the requesting node.
- R5: When an eviction notice clears the last set bit of an entry, that entry is freed. Later snoops to the line return an empty vector, and the freed slot can be reused without a back-invalidate.
- R6: A snoop to an untracked line returns `snp_valid` high with an all-zero target vector. Eviction notices to untracked lines change nothing.
- R7: A fill to an untracked line while all entries are valid raises `binv_valid` for one cycle. `binv_addr` and `binv_nodes` carry the replaced line's address and its owner vector. The new line takes the replaced slot in the same cycle.
- R8: The replaced entry is the one with the fewest set owner bits. Among those, the entry with the largest age is chosen. If ages also tie, the lowest index is chosen.
- R9: A fill to an untracked line always goes to a free entry when one exists, taking the lowest free index, and raises no back-invalidate.
- R10: Each request that hits or allocates an entry sets that entry's age to zero. The same request increments the age of every other valid entry, saturating at 2^AGE_W-1. Snoop misses and eviction-notice misses leave all ages unchanged.
- R11: All outputs are registered. A request's response appears after the first clock edge that samples the request and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 2 | Request type: 0 idle, 1 fill, 2 eviction notice, 3 snoop |
| req_node | input | $clog2(NODES) | Node that issues the fill or the eviction notice |
| req_addr | input | ADDR_W | Cache line address |
| snp_valid | output | 1 | Snoop response is valid |
| snp_targets | output | NODES | Nodes that must be snooped |
| binv_valid | output | 1 | Back-invalidate pulse |
| binv_addr | output | ADDR_W | Address of the replaced line |
| binv_nodes | output | NODES | Owners of the replaced line |

## Verification
A wrong owner bit shows up at the next snoop to that line, one cycle after the snoop request. A wrong valid flag shows up in the same way, or in the absence or presence of a back-invalidate on a later fill. A wrong age or a wrong comparison in victim selection stays hidden until the table is full. It then shows as the wrong address on `binv_addr`, possibly many requests after the error arose. For that reason the stimulus keeps the table full for long stretches, using a small address pool. It also drives directed ties of owner count, both with and without saturated ages.

// File: rtl/snoop_filter.sv
`timescale 1ns/1ps
module snoop_filter #(
  parameter int NODES   = 4,
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16,
  parameter int AGE_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               req_op,
  input  logic [$clog2(NODES)-1:0] req_node,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic                     snp_valid,
  output logic [NODES-1:0]         snp_targets,
  output logic                     binv_valid,
  output logic [ADDR_W-1:0]        binv_addr,
  output logic [NODES-1:0]         binv_nodes
);
  localparam int IW = $clog2(ENTRIES);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
  localparam logic [1:0] OP_FILL = 2'd1, OP_EVICT = 2'd2, OP_SNOOP = 2'd3;

  logic [ENTRIES-1:0] vld;
  logic [ADDR_W-1:0]  tag [ENTRIES];
  logic [NODES-1:0]   pv  [ENTRIES];
  logic [AGE_W-1:0]   age [ENTRIES];

  logic [ENTRIES-1:0] hitv;
  logic [IW-1:0]      hit_idx, free_idx, vic_idx, tidx;
  int                 bc, ba;

  always_comb begin
    hitv = '0; hit_idx = '0; free_idx = '0; vic_idx = '0;
    bc = NODES + 1; ba = -1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      hitv[i] = vld[i] && (tag[i] == req_addr);
      if (hitv[i]) hit_idx = IW'(i);
      if (!vld[i]) free_idx = IW'(i);
    end
    for (int i = 0; i < ENTRIES; i++)
      if ($countones(pv[i]) < bc || ($countones(pv[i]) == bc && int'(age[i]) > ba)) begin
        bc = $countones(pv[i]);
        ba = int'(age[i]);
        vic_idx = IW'(i);
      end
  end

  wire              hit      = |hitv;
  wire              has_free = ~&vld;
  wire [NODES-1:0]  node_bit = NODES'(1) << req_node;
  wire              do_alloc = (req_op == OP_FILL) && !hit;
  wire              touch    = (req_op == OP_FILL) || ((req_op != 2'd0) && hit);
  assign tidx = hit ? hit_idx : (has_free ? free_idx : vic_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      snp_valid <= 1'b0; snp_targets <= '0;
      binv_valid <= 1'b0; binv_addr <= '0; binv_nodes <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i] <= '0; pv[i] <= '0; age[i] <= '0;
      end
    end else begin
      snp_valid   <= (req_op == OP_SNOOP);
      snp_targets <= (req_op == OP_SNOOP && hit) ? pv[hit_idx] : '0;
      binv_valid  <= do_alloc && !has_free;
      binv_addr   <= (do_alloc && !has_free) ? tag[vic_idx] : '0;
      binv_nodes  <= (do_alloc && !has_free) ? pv[vic_idx]  : '0;
      if (touch)
        for (int i = 0; i < ENTRIES; i++)
          if (IW'(i) == tidx) age[i] <= '0;
          else if (vld[i] && age[i] != AGE_MAX) age[i] <= age[i] + 1'b1;
      if (req_op == OP_FILL) begin
        if (hit) pv[hit_idx] <= pv[hit_idx] | node_bit;
        else begin
          vld[tidx] <= 1'b1;
          tag[tidx] <= req_addr;
          pv[tidx]  <= node_bit;
        end
      end else if (req_op == OP_EVICT && hit) begin
        pv[hit_idx] <= pv[hit_idx] & ~node_bit;
        if ((pv[hit_idx] & ~node_bit) == '0) vld[hit_idx] <= 1'b0;
      end
    end
  end

  // R2
  no_dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hitv));

  // R7
  binv_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    binv_valid |-> (&vld && binv_nodes != '0));

  // R11
  binv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    binv_valid |-> $past(req_op) == OP_FILL);

  // R11
  snp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> $past(req_op) == OP_SNOOP);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_live
    // R5
    live_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld[g] |-> pv[g] != '0);
  end
endmodule

// File: tb/snoop_filter_tb_top.sv
`timescale 1ns/1ps
module snoop_filter_tb_top;
  localparam int N = 4, E = 8, AW = 16, AGEW = 3;
  localparam int AMAX = (1 << AGEW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [1:0] req_node = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic snp_valid, binv_valid;
  logic [N-1:0] snp_targets, binv_nodes;
  logic [AW-1:0] binv_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  snoop_filter #(.NODES(N), .ENTRIES(E), .ADDR_W(AW), .AGE_W(AGEW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_node(req_node), .req_addr(req_addr),
    .snp_valid(snp_valid), .snp_targets(snp_targets),
    .binv_valid(binv_valid), .binv_addr(binv_addr), .binv_nodes(binv_nodes));

  bit            mv [E];
  logic [AW-1:0] mt [E];
  logic [N-1:0]  mp [E];
  int            ma [E];

  task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [1:0] op, input int node, input logic [AW-1:0] addr, input string tag);
    int h = -1, f = -1, v = 0, bc = N + 1, ba = -1, t = -1;
    logic [N-1:0] nb = N'(1) << node;
    logic e_sv, e_bv;
    logic [N-1:0] e_st, e_bn;
    logic [AW-1:0] e_ba;
    logic [63:0] act, exp;
    req_op = op; req_node = node[1:0]; req_addr = addr;
    for (int i = 0; i < E; i++) begin
      if (mv[i] && mt[i] == addr && h < 0) h = i;
      if (!mv[i] && f < 0) f = i;
    end
    for (int i = 0; i < E; i++)
      if ($countones(mp[i]) < bc || ($countones(mp[i]) == bc && ma[i] > ba)) begin
        bc = $countones(mp[i]); ba = ma[i]; v = i;
      end
    e_sv = (op == 2'd3);
    e_st = (op == 2'd3 && h >= 0) ? mp[h] : '0;
    e_bv = 0; e_ba = '0; e_bn = '0;
    if (op == 2'd1) t = (h >= 0) ? h : (f >= 0 ? f : v);
    else if (op != 2'd0 && h >= 0) t = h;
    if (t >= 0)
      for (int i = 0; i < E; i++)
        if (i == t) ma[i] = 0;
        else if (mv[i] && ma[i] < AMAX) ma[i]++;
    if (op == 2'd1) begin
      if (h >= 0) mp[h] |= nb;
      else begin
        if (f < 0) begin e_bv = 1; e_ba = mt[v]; e_bn = mp[v]; end
        mv[t] = 1; mt[t] = addr; mp[t] = nb;
      end
    end else if (op == 2'd2 && h >= 0) begin
      mp[h] &= ~nb;
      if (mp[h] == '0) mv[h] = 0;
    end
    @(negedge clk);
    act = {26'd0, snp_valid, snp_targets, binv_valid, binv_addr, binv_nodes};
    exp = {26'd0, e_sv, e_st, e_bv, e_ba, e_bn};
    chk(tag, act == exp, act, exp);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < E; i++) begin mv[i] = 0; mt[i] = '0; mp[i] = '0; ma[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", {snp_valid, snp_targets, binv_valid, binv_addr, binv_nodes} == '0,
        {snp_valid, snp_targets, binv_valid, binv_addr, binv_nodes}, 0);
    req(2'd3, 0, 16'h100, "R1");
    req(2'd3, 1, 16'h1FF, "R6");
    req(2'd2, 1, 16'h1FF, "R6");
    req(2'd1, 0, 16'h100, "R2");
    req(2'd3, 0, 16'h100, "R2");
    chk("R2", snp_targets == 4'b0001, snp_targets, 4'b0001);
    req(2'd1, 2, 16'h100, "R3");
    req(2'd3, 0, 16'h100, "R3");
    chk("R3", snp_targets == 4'b0101, snp_targets, 4'b0101);
    req(2'd2, 0, 16'h100, "R4");
    req(2'd3, 0, 16'h100, "R4");
    req(2'd2, 2, 16'h100, "R5");
    req(2'd3, 0, 16'h100, "R5");
    for (int a = 0; a < 8; a++) req(2'd1, 0, 16'h100 + 16'(a), "R9");
    for (int a = 0; a < 8; a++) if (a != 3 && a != 5) req(2'd1, 1, 16'h100 + 16'(a), "R3");
    req(2'd3, 0, 16'h103, "R10");
    req(2'd1, 3, 16'h108, "R7");
    chk("R8", binv_valid && binv_addr == 16'h105 && binv_nodes == 4'b0001, binv_addr, 16'h105);
    req(2'd0, 0, 16'h000, "R11");
    chk("R11", !binv_valid && !snp_valid, {binv_valid, snp_valid}, 0);
    for (int k = 0; k < 10; k++) req(2'd3, 0, 16'h100, "R10");
    req(2'd1, 1, 16'h109, "R10");
    chk("R10", binv_valid && binv_addr == 16'h103, binv_addr, 16'h103);
    req(2'd2, 0, 16'h104, "R4");
    req(2'd2, 1, 16'h104, "R5");
    req(2'd1, 2, 16'h10A, "R5");
    chk("R5", !binv_valid, binv_valid, 0);
    seed = $urandom(32'h1234);
    for (int k = 0; k < 3000; k++) begin
      int op = int'($urandom_range(3, 0));
      int nd = int'($urandom_range(N - 1, 0));
      logic [AW-1:0] ad = 16'h100 + 16'($urandom_range(11, 0));
      case (op)
        1: req(2'd1, nd, ad, "R7");
        2: req(2'd2, nd, ad, "R4");
        3: req(2'd3, nd, ad, "R2");
        default: req(2'd0, nd, ad, "R11");
      endcase
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule